// File: doc/BRIEF.md
# Circular Reorder Buffer with Grouped Retirement

This block keeps program order for micro-ops that execute out of order. It holds 40 entries in a ring. On the allocation side, a group of up to three micro-ops enters each cycle. Each micro-op receives a 6-bit entry index, and downstream logic uses that index as the micro-op's physical destination tag. Execution units later report a micro-op as finished by sending its index on the completion port, in any order, together with a fault flag. A fault covers both an exception and a branch misprediction.

Each cycle, the retire side looks at the three oldest entries and releases finished micro-ops from the oldest one. Each entry records whether it is the last micro-op of its instruction. A retire group therefore always ends on an instruction boundary, and an instruction that does not fit in the remaining slots waits for the next cycle.

When a finished instruction at the front carries a fault, the block raises a flush event that names the first discarded entry and the number of entries discarded. The buffer is empty on the following clock. The block emits allocation, retire and flush events only. It stores no result data and updates no rename table.

Top module: `rob_ring`

## Requirements
- R1: A request of `alloc_cnt` = 1..3 micro-ops is accepted whole. Acceptance is signalled by `alloc_ok`. Slot k of the group receives index (tail + k) mod 40 on bits [6k+5:6k] of `alloc_idx`, and slot 0 is the oldest. The tail starts at 0 after reset and advances by the accepted count.
- R2: When the request exceeds the free entries, `alloc_stall` is 1, `alloc_ok` is 0 and nothing is allocated. The next accepted group starts at the same tail index. Free entries are counted before any retirement in the same cycle.
- R3: Exactly 40 micro-ops fit. From empty, 40 single allocations are accepted, and then any further request stalls.
- R4: Retirement releases between 1 and 3 entries per cycle, oldest first, and only entries that are complete. `ret_idx` is the oldest entry, and `ret_cnt` entries from it are released. An entry completed at a clock edge can retire in the cycle that follows that edge.
- R5: Completions are accepted in any order. An incomplete oldest entry blocks retirement of every younger entry, even when those younger entries are complete.
- R6: `alloc_eoi[k]` = 1 marks slot k as the last micro-op of its instruction. An instruction retires only when all its micro-ops are complete and all of them fit within the 3-entry window. Instructions are at most 3 micro-ops long.
- R7: When the oldest unretired instruction in the window is fully complete and one of its micro-ops carries a fault, `flush_valid` is 1 in that cycle. In the same cycle:
  - `ret_cnt` counts only the clean instructions ahead of it;
  - `flush_idx` is the faulting instruction's first entry;
  - `flush_cnt` is the number of entries left after those retirements.
  No flush is raised while the faulting instruction is still incomplete.
- R8: In a flush cycle, allocation is refused. From the next cycle the buffer is empty: nothing retires, and a new group starts at the unchanged tail index.
- R9: After reset the buffer is empty. There is no retire, no flush and no stall.
- R10: Indices wrap from 39 to 0, both for allocation and for retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_cnt | input | 2 | Number of micro-ops requested this cycle (0..3) |
| alloc_eoi | input | 3 | Per slot: last micro-op of its instruction |
| alloc_ok | output | 1 | Requested group accepted |
| alloc_stall | output | 1 | Request refused for lack of room or because of a flush |
| alloc_idx | output | 18 | Entry index for each slot, 6 bits per slot |
| cmp_valid | input | 1 | Completion report valid |
| cmp_idx | input | 6 | Index of the completed entry |
| cmp_fault | input | 1 | Completed micro-op raised an exception or mispredict |
| ret_valid | output | 1 | At least one entry retires this cycle |
| ret_idx | output | 6 | Oldest retiring entry |
| ret_cnt | output | 2 | Number of entries retiring |
| flush_valid | output | 1 | Fault at the front: discard speculative state |
| flush_idx | output | 6 | First discarded entry |
| flush_cnt | output | 6 | Number of discarded entries |

## Verification
The allocation, retire and flush outputs are combinational views of the current state and the inputs, so each one is due in the same cycle that its stimulus or state is presented. A completion changes retire outputs only in the cycle after the edge that records it. A flush leaves the buffer empty in the cycle after the flush is raised. The bench drives inputs on the falling edge and samples the outputs 4 ns later, before the next rising edge. Every expectation is therefore compared in the cycle it is due. Expected indices come from a tail and head count kept in the bench and reduced modulo 40.

// File: rtl/rob_pkg.sv
// Shared helpers for the reorder buffer: ring arithmetic on entry indices.
// Assumes operands are already below the ring depth.
package rob_pkg;

    // (a + b) mod depth for a < depth and b <= depth
    function automatic int ring_add(input int a, input int b, input int depth);
        int s;
        s = a + b;
        if (s >= depth) s = s - depth;
        return s;
    endfunction

    // distance walking forward from 'from' to 'to' on the ring
    function automatic int ring_dist(input int from, input int to, input int depth);
        return (to >= from) ? (to - from) : (to + depth - from);
    endfunction

endpackage

// File: rtl/rob_ptr_ctl.sv
// Head/tail pointer control of the ring. Each pointer carries a wrap bit so
// that full (40 used) and empty (0 used) are told apart. Decides whether an
// allocation group fits (all-or-none) and moves the head on retire or flush.
// Assumes ret_cnt never exceeds occupancy and flush blocks allocation.
module rob_ptr_ctl #(
    parameter int DEPTH   = 40,
    parameter int ALLOC_W = 3,
    parameter int RET_W   = 3,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int OCC_W  = $clog2(DEPTH + 1),
    localparam int ACNT_W = $clog2(ALLOC_W + 1),
    localparam int RCNT_W = $clog2(RET_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACNT_W-1:0] alloc_cnt,
    input  logic [RCNT_W-1:0] ret_cnt,
    input  logic              flush,
    output logic [IDX_W-1:0]  head_idx,
    output logic [IDX_W-1:0]  tail_idx,
    output logic [OCC_W-1:0]  occ,
    output logic              alloc_fire
);
    localparam int SUM_W = IDX_W + 1;

    logic             head_wrap, tail_wrap;
    logic [OCC_W-1:0] free_cnt;
    logic [SUM_W-1:0] tail_sum, head_sum;

    // occupancy from pointers; equal wrap bits mean the tail has not lapped
    always_comb begin
        if (head_wrap == tail_wrap)
            occ = OCC_W'(tail_idx) - OCC_W'(head_idx);
        else
            occ = OCC_W'(DEPTH) - OCC_W'(head_idx) + OCC_W'(tail_idx);
        free_cnt = OCC_W'(DEPTH) - occ;
    end

    // all-or-none acceptance of the requested group
    always_comb begin
        alloc_fire = (alloc_cnt != '0) && (OCC_W'(alloc_cnt) <= free_cnt) && !flush;
    end

    // raw next positions before ring reduction
    always_comb begin
        tail_sum = {1'b0, tail_idx} + SUM_W'(alloc_cnt);
        head_sum = {1'b0, head_idx} + SUM_W'(ret_cnt);
    end

    // tail advances on accepted allocation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_idx  <= '0;
            tail_wrap <= 1'b0;
        end else if (alloc_fire) begin
            if (tail_sum >= SUM_W'(DEPTH)) begin
                tail_idx  <= IDX_W'(tail_sum - SUM_W'(DEPTH));
                tail_wrap <= ~tail_wrap;
            end else begin
                tail_idx  <= IDX_W'(tail_sum);
            end
        end
    end

    // head advances on retire, or snaps to the tail on flush (buffer empty)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_idx  <= '0;
            head_wrap <= 1'b0;
        end else if (flush) begin
            head_idx  <= tail_idx;
            head_wrap <= tail_wrap;
        end else if (ret_cnt != '0) begin
            if (head_sum >= SUM_W'(DEPTH)) begin
                head_idx  <= IDX_W'(head_sum - SUM_W'(DEPTH));
                head_wrap <= ~head_wrap;
            end else begin
                head_idx  <= IDX_W'(head_sum);
            end
        end
    end

endmodule

// File: rtl/rob_entry_array.sv
// Per-entry state: occupied, complete, fault and end-of-instruction bits.
// Allocation writes a fresh entry, completion marks an occupied entry done
// and records its fault, retirement and flush free entries.
// Assumes allocated and retiring ranges never overlap (guaranteed by the
// pointer control) and ignores completions to unoccupied entries.
module rob_entry_array #(
    parameter int DEPTH   = 40,
    parameter int ALLOC_W = 3,
    parameter int RET_W   = 3,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int ACNT_W = $clog2(ALLOC_W + 1),
    localparam int RCNT_W = $clog2(RET_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_fire,
    input  logic [ACNT_W-1:0]  alloc_cnt,
    input  logic [IDX_W-1:0]   alloc_base,
    input  logic [ALLOC_W-1:0] alloc_eoi,
    input  logic               cmp_valid,
    input  logic [IDX_W-1:0]   cmp_idx,
    input  logic               cmp_fault,
    input  logic [IDX_W-1:0]   ret_base,
    input  logic [RCNT_W-1:0]  ret_cnt,
    input  logic               flush,
    output logic [DEPTH-1:0]   ent_done,
    output logic [DEPTH-1:0]   ent_fault,
    output logic [DEPTH-1:0]   ent_eoi
);
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic             valid_q, done_q, fault_q, eoi_q;
        logic [IDX_W-1:0] a_off, r_off;
        logic             a_hit, r_hit, c_hit, eoi_in;

        // decode which port touches this entry
        always_comb begin
            a_off  = IDX_W'(rob_pkg::ring_dist(int'(alloc_base), e, DEPTH));
            r_off  = IDX_W'(rob_pkg::ring_dist(int'(ret_base), e, DEPTH));
            a_hit  = alloc_fire && (a_off < IDX_W'(alloc_cnt));
            r_hit  = r_off < IDX_W'(ret_cnt);
            c_hit  = cmp_valid && (cmp_idx == IDX_W'(e)) && valid_q;
            eoi_in = 1'b0;
            for (int k = 0; k < ALLOC_W; k++)
                if (a_off == IDX_W'(k)) eoi_in = alloc_eoi[k];
        end

        // entry state update; flush wins over everything
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q <= 1'b0;
                done_q  <= 1'b0;
                fault_q <= 1'b0;
                eoi_q   <= 1'b0;
            end else if (flush) begin
                valid_q <= 1'b0;
            end else if (a_hit) begin
                valid_q <= 1'b1;
                done_q  <= 1'b0;
                fault_q <= 1'b0;
                eoi_q   <= eoi_in;
            end else if (r_hit) begin
                valid_q <= 1'b0;
            end else if (c_hit) begin
                done_q  <= 1'b1;
                fault_q <= cmp_fault;
            end
        end

        assign ent_done[e]  = valid_q & done_q;
        assign ent_fault[e] = fault_q;
        assign ent_eoi[e]   = eoi_q;
    end

endmodule

// File: rtl/rob_retire_sel.sv
// Chooses the retire group from the oldest RET_W entries. Walks the window
// instruction by instruction: a finished clean instruction joins the group,
// a finished faulting one raises flush and ends the walk, an unfinished one
// (or one whose last micro-op lies past the window) ends the walk.
// Assumes window entries beyond occupancy are masked by 'occ'.
module rob_retire_sel #(
    parameter int DEPTH   = 40,
    parameter int RET_W   = 3,
    localparam int OCC_W  = $clog2(DEPTH + 1),
    localparam int RCNT_W = $clog2(RET_W + 1)
) (
    input  logic [OCC_W-1:0]  occ,
    input  logic [RET_W-1:0]  win_done,
    input  logic [RET_W-1:0]  win_fault,
    input  logic [RET_W-1:0]  win_eoi,
    output logic [RCNT_W-1:0] ret_cnt,
    output logic              flush
);
    // instruction-granular walk over the window
    always_comb begin
        int   cnt_v;
        logic all_done, any_fault, stop, flush_v;
        cnt_v     = 0;
        all_done  = 1'b1;
        any_fault = 1'b0;
        stop      = 1'b0;
        flush_v   = 1'b0;
        for (int k = 0; k < RET_W; k++) begin
            if (!stop) begin
                if (OCC_W'(k) >= occ) begin
                    stop = 1'b1;
                end else begin
                    all_done  = all_done & win_done[k];
                    any_fault = any_fault | (win_done[k] & win_fault[k]);
                    if (win_eoi[k]) begin
                        if (!all_done) begin
                            stop = 1'b1;
                        end else if (any_fault) begin
                            flush_v = 1'b1;
                            stop    = 1'b1;
                        end else begin
                            cnt_v     = k + 1;
                            all_done  = 1'b1;
                            any_fault = 1'b0;
                        end
                    end
                end
            end
        end
        ret_cnt = RCNT_W'(cnt_v);
        flush   = flush_v;
    end

endmodule

// File: rtl/rob_ring.sv
// Top of the circular reorder buffer. Hands out ring indices to allocation
// groups, records out-of-order completions, and retires whole instructions
// oldest first, up to RET_W entries per cycle. A finished faulting
// instruction at the front raises flush; the buffer is empty next clock.
// Assumes instructions span at most RET_W micro-ops.
module rob_ring #(
    parameter int DEPTH   = 40,
    parameter int ALLOC_W = 3,
    parameter int RET_W   = 3,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int OCC_W  = $clog2(DEPTH + 1),
    localparam int ACNT_W = $clog2(ALLOC_W + 1),
    localparam int RCNT_W = $clog2(RET_W + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ACNT_W-1:0]        alloc_cnt,
    input  logic [ALLOC_W-1:0]       alloc_eoi,
    output logic                     alloc_ok,
    output logic                     alloc_stall,
    output logic [ALLOC_W*IDX_W-1:0] alloc_idx,
    input  logic                     cmp_valid,
    input  logic [IDX_W-1:0]         cmp_idx,
    input  logic                     cmp_fault,
    output logic                     ret_valid,
    output logic [IDX_W-1:0]         ret_idx,
    output logic [RCNT_W-1:0]        ret_cnt,
    output logic                     flush_valid,
    output logic [IDX_W-1:0]         flush_idx,
    output logic [OCC_W-1:0]         flush_cnt
);
    logic [IDX_W-1:0]  head_idx, tail_idx;
    logic [OCC_W-1:0]  occ;
    logic              alloc_fire, flush;
    logic [RCNT_W-1:0] sel_cnt;
    logic [DEPTH-1:0]  ent_done, ent_fault, ent_eoi;
    logic [RET_W-1:0]  win_done, win_fault, win_eoi;

    rob_ptr_ctl #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .RET_W(RET_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_cnt  (alloc_cnt),
        .ret_cnt    (sel_cnt),
        .flush      (flush),
        .head_idx   (head_idx),
        .tail_idx   (tail_idx),
        .occ        (occ),
        .alloc_fire (alloc_fire)
    );

    rob_entry_array #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .RET_W(RET_W)) u_ent (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_fire (alloc_fire),
        .alloc_cnt  (alloc_cnt),
        .alloc_base (tail_idx),
        .alloc_eoi  (alloc_eoi),
        .cmp_valid  (cmp_valid),
        .cmp_idx    (cmp_idx),
        .cmp_fault  (cmp_fault),
        .ret_base   (head_idx),
        .ret_cnt    (sel_cnt),
        .flush      (flush),
        .ent_done   (ent_done),
        .ent_fault  (ent_fault),
        .ent_eoi    (ent_eoi)
    );

    // gather the oldest RET_W entries into the retire window
    for (genvar k = 0; k < RET_W; k++) begin : g_win
        logic [IDX_W-1:0] w_idx;
        assign w_idx        = IDX_W'(rob_pkg::ring_add(int'(head_idx), k, DEPTH));
        assign win_done[k]  = ent_done[w_idx];
        assign win_fault[k] = ent_fault[w_idx];
        assign win_eoi[k]   = ent_eoi[w_idx];
    end

    rob_retire_sel #(.DEPTH(DEPTH), .RET_W(RET_W)) u_sel (
        .occ       (occ),
        .win_done  (win_done),
        .win_fault (win_fault),
        .win_eoi   (win_eoi),
        .ret_cnt   (sel_cnt),
        .flush     (flush)
    );

    // consecutive ring indices for each allocation slot
    for (genvar k = 0; k < ALLOC_W; k++) begin : g_aidx
        assign alloc_idx[k*IDX_W +: IDX_W] =
            IDX_W'(rob_pkg::ring_add(int'(tail_idx), k, DEPTH));
    end

    // event outputs
    always_comb begin
        alloc_ok    = alloc_fire;
        alloc_stall = (alloc_cnt != '0) && !alloc_fire;
        ret_cnt     = sel_cnt;
        ret_valid   = (sel_cnt != '0);
        ret_idx     = head_idx;
        flush_valid = flush;
        flush_idx   = IDX_W'(rob_pkg::ring_add(int'(head_idx), int'(sel_cnt), DEPTH));
        flush_cnt   = occ - OCC_W'(sel_cnt);
    end

endmodule

// File: rtl/rob_ring_chk.sv
// Assertion checker for rob_ring, attached with bind. Observes ports only.
module rob_ring_chk #(
    parameter int DEPTH   = 40,
    parameter int ALLOC_W = 3,
    parameter int RET_W   = 3,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int OCC_W  = $clog2(DEPTH + 1),
    localparam int ACNT_W = $clog2(ALLOC_W + 1),
    localparam int RCNT_W = $clog2(RET_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ACNT_W-1:0] alloc_cnt,
    input logic              alloc_ok,
    input logic              alloc_stall,
    input logic [IDX_W-1:0]  alloc_idx0,
    input logic              ret_valid,
    input logic [IDX_W-1:0]  ret_idx,
    input logic [RCNT_W-1:0] ret_cnt,
    input logic              flush_valid,
    input logic [OCC_W-1:0]  flush_cnt
);
    p_stall_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_stall |-> !alloc_ok);

    p_ok_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ok |-> (alloc_cnt != '0));

    p_tail_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_ok && $past(alloc_ok)) |->
        (int'(alloc_idx0) == rob_pkg::ring_add(int'($past(alloc_idx0)),
                                               int'($past(alloc_cnt)), DEPTH)));

    p_idx_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ok |-> (int'(alloc_idx0) < DEPTH));

    p_ret_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> (int'(ret_cnt) <= RET_W));

    p_ret_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ret_valid) && !$past(flush_valid) && ret_valid) |->
        (int'(ret_idx) == rob_pkg::ring_add(int'($past(ret_idx)),
                                            int'($past(ret_cnt)), DEPTH)));

    p_flush_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> (flush_cnt != '0) && (int'(flush_cnt) <= DEPTH));

    p_flush_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> !alloc_ok);

    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> (!ret_valid && !flush_valid));

endmodule

bind rob_ring rob_ring_chk #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .RET_W(RET_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_cnt   (alloc_cnt),
    .alloc_ok    (alloc_ok),
    .alloc_stall (alloc_stall),
    .alloc_idx0  (alloc_idx[IDX_W-1:0]),
    .ret_valid   (ret_valid),
    .ret_idx     (ret_idx),
    .ret_cnt     (ret_cnt),
    .flush_valid (flush_valid),
    .flush_cnt   (flush_cnt)
);

// File: tb/tb_rob_ring.sv
module tb_rob_ring;
    localparam int D = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  alloc_cnt = '0;
    logic [2:0]  alloc_eoi = '0;
    logic        alloc_ok, alloc_stall;
    logic [17:0] alloc_idx;
    logic        cmp_valid = 1'b0;
    logic [5:0]  cmp_idx = '0;
    logic        cmp_fault = 1'b0;
    logic        ret_valid;
    logic [5:0]  ret_idx;
    logic [1:0]  ret_cnt;
    logic        flush_valid;
    logic [5:0]  flush_idx;
    logic [5:0]  flush_cnt;

    int nchk = 0, nerr = 0;
    int tl = 0;
    int o_ok, o_stall, o_rv, o_ri, o_rc, o_fv, o_fi, o_fc;
    int o_idx [3];
    bit done_flag = 0;

    rob_ring dut (
        .clk(clk), .rst_n(rst_n), .alloc_cnt(alloc_cnt), .alloc_eoi(alloc_eoi),
        .alloc_ok(alloc_ok), .alloc_stall(alloc_stall), .alloc_idx(alloc_idx),
        .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_fault(cmp_fault),
        .ret_valid(ret_valid), .ret_idx(ret_idx), .ret_cnt(ret_cnt),
        .flush_valid(flush_valid), .flush_idx(flush_idx), .flush_cnt(flush_cnt)
    );

    always #5 clk = ~clk;

    function automatic int md(input int x);
        return x % D;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive on falling edge, sample 4 ns later, before the next rising edge
    task automatic step(input int ac, input logic [2:0] ae, input bit cv,
                        input int ci, input bit cf);
        @(negedge clk);
        alloc_cnt = 2'(ac);
        alloc_eoi = ae;
        cmp_valid = cv;
        cmp_idx   = 6'(ci);
        cmp_fault = cf;
        #4;
        o_ok = alloc_ok; o_stall = alloc_stall;
        for (int k = 0; k < 3; k++) o_idx[k] = int'(alloc_idx[k*6 +: 6]);
        o_rv = ret_valid; o_ri = ret_idx; o_rc = ret_cnt;
        o_fv = flush_valid; o_fi = flush_idx; o_fc = flush_cnt;
    endtask

    task automatic idle();
        step(0, 3'b000, 0, 0, 0);
    endtask

    task automatic cmp(input int i, input bit f);
        step(0, 3'b000, 1, i, f);
    endtask

    // accepted allocation with index check against the bench tail
    task automatic alloc_chk(input int cnt, input logic [2:0] eoi, input string tag);
        step(cnt, eoi, 0, 0, 0);
        chk({tag, " alloc_ok"}, o_ok, 1);
        for (int k = 0; k < cnt; k++) chk({tag, " alloc_idx"}, o_idx[k], md(tl + k));
        tl = md(tl + cnt);
    endtask

    task automatic ret_chk(input int cnt, input int idx, input string tag);
        idle();
        chk({tag, " ret_cnt"}, o_rc, cnt);
        if (cnt != 0) chk({tag, " ret_idx"}, o_ri, idx);
        else chk({tag, " ret_valid"}, o_rv, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        idle();
        chk("R9 ret_valid", o_rv, 0);
        chk("R9 flush_valid", o_fv, 0);
        chk("R9 alloc_stall", o_stall, 0);

        // R1/R3: fill 40 entries from empty, 3 per cycle then 1
        for (int c = 0; c < 13; c++) alloc_chk(3, 3'b111, "R1");
        step(3, 3'b111, 0, 0, 0);
        chk("R2 stall on short room", o_stall, 1);
        chk("R2 no ok", o_ok, 0);
        alloc_chk(1, 3'b001, "R2 tail kept");
        step(1, 3'b001, 0, 0, 0);
        chk("R3 stall when full", o_stall, 1);
        chk("R4 nothing done no retire", o_rv, 0);

        // R5: complete youngest first; head incomplete blocks retirement
        for (int i = D - 1; i >= 0; i--) begin
            cmp(i, 0);
            chk("R5 blocked by head", o_rv, 0);
        end
        for (int c = 0; c < 13; c++) ret_chk(3, 3 * c, "R4");
        ret_chk(1, 39, "R4 last");
        ret_chk(0, 0, "R4 empty");

        // R10: move head to 2, then wrap allocation and retirement
        alloc_chk(2, 3'b011, "R1 pair");
        cmp(0, 0);
        cmp(1, 0);
        chk("R4 partial cnt", o_rc, 1);
        chk("R4 partial idx", o_ri, 0);
        ret_chk(1, 1, "R4 second");
        for (int c = 0; c < 13; c++) alloc_chk(3, 3'b111, "R10");
        alloc_chk(1, 3'b001, "R10 last");
        step(1, 3'b001, 0, 0, 0);
        chk("R3 full after wrap", o_stall, 1);
        cmp(2, 0);
        for (int j = 1; j < D; j++) begin
            cmp(md(2 + j), 0);
            chk("R10 ret_cnt", o_rc, 1);
            chk("R10 ret_idx", o_ri, md(2 + j - 1));
        end
        ret_chk(1, 1, "R10 final");
        ret_chk(0, 0, "R10 empty");

        // R6: two 2-uop instructions at 2..5; then a 3-uop one at 6..8
        alloc_chk(3, 3'b010, "R6 a");
        alloc_chk(1, 3'b001, "R6 b");
        cmp(3, 0); chk("R6 wait", o_rv, 0);
        cmp(5, 0); chk("R6 wait", o_rv, 0);
        cmp(4, 0); chk("R6 wait", o_rv, 0);
        cmp(2, 0); chk("R6 wait", o_rv, 0);
        ret_chk(2, 2, "R6 first instr only");
        ret_chk(2, 4, "R6 second instr");
        ret_chk(0, 0, "R6 empty");
        alloc_chk(3, 3'b100, "R6 triple");
        cmp(6, 0);
        cmp(8, 0);
        chk("R6 middle missing", o_rv, 0);
        cmp(7, 0);
        chk("R6 still waiting", o_rv, 0);
        ret_chk(3, 6, "R6 triple retire");

        // R7/R8: singles at 9,10,11 with fault on 10
        alloc_chk(3, 3'b111, "R7 setup");
        cmp(11, 0); chk("R7 none", o_fv, 0);
        cmp(10, 1); chk("R7 none yet", o_fv, 0);
        cmp(9, 0);  chk("R7 head open", o_fv, 0);
        step(1, 3'b001, 0, 0, 0);
        chk("R7 ret_cnt", o_rc, 1);
        chk("R7 ret_idx", o_ri, 9);
        chk("R7 flush_valid", o_fv, 1);
        chk("R7 flush_idx", o_fi, 10);
        chk("R7 flush_cnt", o_fc, 2);
        chk("R8 alloc refused", o_ok, 0);
        alloc_chk(3, 3'b111, "R8 after flush");
        chk("R8 no retire", o_rv, 0);
        chk("R8 no flush", o_fv, 0);
        cmp(12, 0);
        cmp(13, 0);
        chk("R8 fresh cnt", o_rc, 1);
        chk("R8 fresh idx", o_ri, 12);
        cmp(14, 0);
        ret_chk(1, 14, "R8 drain");
        ret_chk(0, 0, "R8 empty");

        // R7: fault in an incomplete 2-uop instruction at 15,16
        alloc_chk(2, 3'b010, "R7 pair");
        cmp(15, 1);
        idle();
        chk("R7 incomplete no flush", o_fv, 0);
        cmp(16, 0);
        chk("R7 incomplete no flush", o_fv, 0);
        idle();
        chk("R7 pair flush", o_fv, 1);
        chk("R7 pair flush_idx", o_fi, 15);
        chk("R7 pair flush_cnt", o_fc, 2);
        chk("R7 pair no retire", o_rv, 0);
        idle();
        chk("R8 pair empty", o_fv, 0);
        chk("R8 pair no retire", o_rv, 0);

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule